// File: doc/BRIEF.md
# Dual-Polarity Channel Input Combiner

This block decides, for each of four low-side output stages, whether the gate should be driven. Every channel has one parallel input pin and one software command bit. The pin is first brought into the system clock domain through a short synchronizer. It is then normalized according to a strapped polarity pin, so a normalized 1 always means "switch on". Finally it is merged with the command bit through an operator that software selects at run time: either OR or AND.

A per-channel over-temperature flag acts as a hard override. While it is set, that channel's gate enable is low, whatever the request says. When the flag clears, the channel follows its request again with no software action. The normalized input states are also presented on an output so that a serial read-back path can report them. Software loads the command bits with a load strobe. It selects the operator with one of two set strobes, and the operator holds until the other one is issued.

Top module: `chan_combiner`

## Requirements
- R1: Input pin n affects only gate enable n and read-back bit n; bit positions of `pin_raw`, `cmd_bits`, `ot_flag`, `gate_en` and `in_state` correspond one to one.
- R2: With `pol_hi` = 1 a high pin is an on-request; with `pol_hi` = 0 a low pin is an on-request. `in_state` bit n is 1 exactly when pin n requests on, taking the current polarity into account. Pin and polarity changes reach `in_state` two clock edges after they are applied.
- R3: The inactive level of a pin is 0 under active-high polarity and 1 under active-low polarity. A pin held at its inactive level, with a command bit of 0 in OR mode, gives gate enable 0.
- R4: In OR mode each gate enable is the normalized input OR the channel's command bit.
- R5: In AND mode each gate enable is the normalized input AND the channel's command bit.
- R6: While `rst_n` is low and after it is released, the operator is OR and all command bits are 0; during reset `gate_en` and `in_state` are 0.
- R7: The operator changes only on `op_or_set` or `op_and_set` asserted alone. With neither strobe, or with both strobes together, the operator keeps its value; a command-bit load leaves it unchanged.
- R8: An asserted `ot_flag` bit forces its gate enable to 0 in the same cycle, without waiting for a clock edge.
- R9: When an `ot_flag` bit clears, its gate enable returns to the combined request in the same cycle.
- R10: `cmd_bits` is captured on a clock edge where `cmd_load` is 1 and is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset and sleep, asynchronous |
| pin_raw | input | NCH | Raw parallel input pins, asynchronous |
| pol_hi | input | 1 | Strapped polarity: 1 active high, 0 active low |
| cmd_load | input | 1 | Load strobe for the command bits |
| cmd_bits | input | NCH | Command data bits from software |
| op_or_set | input | 1 | Strobe selecting the OR operator |
| op_and_set | input | 1 | Strobe selecting the AND operator |
| ot_flag | input | NCH | Per-channel over-temperature shutdown indication |
| gate_en | output | NCH | Per-channel gate enable |
| in_state | output | NCH | Normalized input states for read-back |

## Verification
Two functions can land in the same cycle. An over-temperature flag can clear on the very cycle that the operator is switched or the command bits are reloaded, so the resumed gate value must already reflect the new combination. The bench provokes this with random stimulus that changes operator, data, pins and thermal flags together in one step. It also uses directed steps that drop a thermal flag while the operator changes. Each gate enable is judged against a bench function of the pin, polarity, tracked operator, tracked data and flag. The same cycle is also probed between clock edges, which confirms that the thermal override acts without latency.

// File: rtl/chan_combiner.sv
module chan_combiner #(
  parameter int NCH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_raw,
  input  logic           pol_hi,
  input  logic           cmd_load,
  input  logic [NCH-1:0] cmd_bits,
  input  logic           op_or_set,
  input  logic           op_and_set,
  input  logic [NCH-1:0] ot_flag,
  output logic [NCH-1:0] gate_en,
  output logic [NCH-1:0] in_state
);
  localparam int SW = NCH + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {NCH{1'b0}}};

  logic [SW-1:0]  sync_q [SYNC_STAGES];
  logic [NCH-1:0] data_q;
  logic           op_and_q;
  logic [NCH-1:0] req;
  logic           pol_s;
  logic [NCH-1:0] pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= SYNC_RST;
    end else begin
      sync_q[0] <= {pol_hi, pin_raw};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pol_s    = sync_q[SYNC_STAGES-1][NCH];
  assign pin_s    = sync_q[SYNC_STAGES-1][NCH-1:0];
  assign in_state = pol_s ? pin_s : ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      op_and_q <= 1'b0;
    end else begin
      if (cmd_load) data_q <= cmd_bits;
      if (op_or_set ^ op_and_set) op_and_q <= op_and_set;
    end
  end

  assign req     = op_and_q ? (in_state & data_q) : (in_state | data_q);
  assign gate_en = req & ~ot_flag;

  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_or_set ^ op_and_set) |=> $stable(op_and_q)); // R7
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> data_q == $past(cmd_bits)); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_load |=> $stable(data_q)); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_OT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      ot_flag[i] |-> !gate_en[i]); // R8
    AST_OR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_and_q && data_q[i] && !ot_flag[i]) |-> gate_en[i]); // R4
    AST_AND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (op_and_q && !data_q[i]) |-> !gate_en[i]); // R5
  end
endmodule

// File: tb/chan_combiner_test.sv
module chan_combiner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_raw = 4'h0;
  logic       pol_hi = 1'b1;
  logic       cmd_load = 1'b0;
  logic [3:0] cmd_bits = 4'h0;
  logic       op_or_set = 1'b0;
  logic       op_and_set = 1'b0;
  logic [3:0] ot_flag = 4'h0;
  logic [3:0] gate_en;
  logic [3:0] in_state;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_data = 4'h0;
  logic       exp_and = 1'b0;
  logic [3:0] cur_pin = 4'h0;
  logic       cur_pol = 1'b1;

  always #4 clk = ~clk;

  chan_combiner uut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pol_hi(pol_hi),
    .cmd_load(cmd_load), .cmd_bits(cmd_bits), .op_or_set(op_or_set),
    .op_and_set(op_and_set), .ot_flag(ot_flag), .gate_en(gate_en),
    .in_state(in_state)
  );

  function automatic logic [3:0] norm_of(input logic [3:0] p, input logic pol);
    return pol ? p : ~p;
  endfunction

  function automatic logic [3:0] gate_of(input logic [3:0] p, input logic pol,
      input logic [3:0] d, input logic am, input logic [3:0] ot);
    logic [3:0] n;
    n = norm_of(p, pol);
    return (am ? (n & d) : (n | d)) & ~ot;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] p, input logic pol, input logic ld,
      input logic [3:0] d, input logic oor, input logic oand, input logic [3:0] ot);
    @(negedge clk);
    pin_raw = p; pol_hi = pol; cmd_load = ld; cmd_bits = d;
    op_or_set = oor; op_and_set = oand; ot_flag = ot;
    cur_pin = p; cur_pol = pol;
    if (ld) exp_data = d;
    if (oor ^ oand) exp_and = oand;
    @(negedge clk);
    cmd_load = 1'b0; op_or_set = 1'b0; op_and_set = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " in_state"}, in_state, norm_of(cur_pin, cur_pol));
    chk({tag, " gate_en"}, gate_en, gate_of(cur_pin, cur_pol, exp_data, exp_and, ot_flag));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    pin_raw = 4'hF; pol_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 reset gate_en", gate_en, 4'h0);
    chk("R6 reset in_state", in_state, 4'h0);
    pin_raw = 4'h0; pol_hi = 1'b1;
    rst_n = 1'b1;

    apply(4'h0, 1'b1, 0, 4'h0, 0, 0, 4'h0); check_all("R6 defaults idle");
    apply(4'hF, 1'b1, 0, 4'h0, 0, 0, 4'h0); check_all("R6 R4 default OR");

    for (int i = 0; i < 4; i++) begin
      apply(4'(1 << i), 1'b1, 0, 4'h0, 0, 0, 4'h0);
      check_all("R1 onehot map");
    end

    apply(4'h0, 1'b1, 0, 4'h0, 0, 0, 4'h0); check_all("R3 idle active-high");
    chk("R3 off high", gate_en, 4'h0);
    apply(4'hF, 1'b0, 0, 4'h0, 0, 0, 4'h0); check_all("R3 idle active-low");
    chk("R3 off low", gate_en, 4'h0);
    apply(4'h5, 1'b0, 0, 4'h0, 0, 0, 4'h0); check_all("R2 active-low pattern");
    chk("R2 low norm", in_state, 4'hA);

    apply(4'h3, 1'b1, 1, 4'h6, 0, 0, 4'h0); check_all("R10 R4 OR load");
    chk("R4 or value", gate_en, 4'h7);
    apply(4'h3, 1'b1, 0, 4'h6, 0, 1, 4'h0); check_all("R5 AND select");
    chk("R5 and value", gate_en, 4'h2);
    apply(4'h3, 1'b1, 1, 4'hC, 0, 0, 4'h0); check_all("R7 load keeps AND");
    chk("R7 and kept", gate_en, 4'h0);
    apply(4'hF, 1'b1, 0, 4'h3, 1, 1, 4'h0); check_all("R7 both strobes hold");
    chk("R10 data held", gate_en, 4'hC);
    apply(4'h0, 1'b1, 0, 4'h0, 1, 0, 4'h0); check_all("R7 back to OR");
    chk("R7 or value", gate_en, 4'hC);

    apply(4'hF, 1'b1, 0, 4'h0, 0, 0, 4'h0);
    @(negedge clk); ot_flag = 4'h5; #1;
    chk("R8 ot immediate", gate_en, 4'hA);
    @(negedge clk); ot_flag = 4'h0; #1;
    chk("R9 ot release", gate_en, 4'hF);

    @(negedge clk); ot_flag = 4'h2; op_and_set = 1'b1; cmd_load = 1'b1; cmd_bits = 4'h6;
    @(negedge clk); ot_flag = 4'h0; op_and_set = 1'b0; cmd_load = 1'b0;
    exp_and = 1'b1; exp_data = 4'h6; #1;
    chk("R9 release after AND", gate_en, 4'h6);

    for (int k = 0; k < 200; k++) begin
      logic [3:0] rp, rd, ro;
      logic rpol, rld, ror, rand_;
      rp = 4'($urandom); rd = 4'($urandom);
      ro = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      rpol = 1'($urandom); rld = 1'($urandom);
      ror = 1'($urandom); rand_ = 1'($urandom);
      apply(rp, rpol, rld, rd, ror, rand_, ro);
      check_all("R2 R4 R5 R8 random");
    end

    @(negedge clk); rst_n = 1'b0; #1;
    chk("R6 mid reset gate", gate_en, 4'h0);
    chk("R6 mid reset in", in_state, 4'h0);
    exp_data = 4'h0; exp_and = 1'b0; ot_flag = 4'h0;
    @(negedge clk); rst_n = 1'b1;
    apply(4'h9, 1'b1, 0, 4'h0, 0, 0, 4'h0); check_all("R6 after reset OR");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule